// File: doc/BRIEF.md
# Ambient Light Sensor Bus Sequencer

This block is an I2C master that runs on its own to poll a 16-bit ambient light sensor. It needs no host commands. It derives SCL from the system clock through a divider. It pulls the two bus lines low through open-drain enables and reads the data line back. After reset it waits for the sensor to power up, writes a measurement command, waits out the conversion time, then reads the two result bytes. It presents the raw count and a lux value together with a one-cycle valid strobe.

Two static inputs configure the block. `addr_sel` chooses which of the sensor's two bus addresses is used. `oneshot_mode` chooses continuous polling or single measurements. In continuous mode the command is written once, and after that only read frames are issued. In one-shot mode the sensor sleeps after each result, so the block writes the command again before every read. If a written byte is not acknowledged, the block raises an error flag, ends the frame and starts over with the command.

Top module: `als_i2c_seq`

## Requirements
- R1: The 7-bit target address is 1011100 when `addr_sel` is 1 and 0100011 when it is 0. The first byte of every frame is the address shifted left by one, with bit 0 set to 0 for a write and 1 for a read (for example 0x46/0x47 and 0xB8/0xB9).
- R2: With `oneshot_mode` at 0, the first frame after reset is a write of command byte 0x10. Every frame after it is a read frame.
- R3: With `oneshot_mode` at 1, a write of command byte 0x20 comes before every read frame.
- R4: The first START comes at least PWRUP_CYC clocks after reset is released. A read START comes at least CONV_CYC clocks after the STOP of a command write. In continuous mode, consecutive reads are separated by at least GAP_CYC clocks from STOP to START. No wait exceeds its minimum by more than CLK_DIV+8 clocks.
- R5: SDA changes only while SCL is low. The exceptions are START (SDA falls with SCL high) and STOP (SDA rises with SCL high). Both lines are released while no frame is in progress.
- R6: A read frame takes the high byte first and then the low byte. The master drives ACK (low) after the high byte and NACK (released, high) after the low byte, then sends STOP. `raw_count` = {high, low}.
- R7: `lux` = floor(`raw_count` * 10 / 12). It is updated in the same cycle as `raw_count`, and `sample_valid` is high for exactly that one cycle.
- R8: A high level in the acknowledge slot of a byte the master wrote ends the frame with a STOP. It sets `nack_error` and restarts with the command write. `nack_error` stays set until the next valid sample clears it.
- R9: The SCL period during a frame is exactly CLK_DIV clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Static address select |
| oneshot_mode | input | 1 | Static mode: 0 continuous, 1 one-shot |
| sda_in | input | 1 | Level read back from the SDA line |
| scl_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_low | output | 1 | Pull SDA low when 1, release when 0 |
| raw_count | output | 16 | Last raw sensor count |
| lux | output | 16 | Raw count scaled by 10/12 |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |
| nack_error | output | 1 | Sticky missing-acknowledge flag |

## Verification
Each result is checked at the point where it becomes due. The sample registers and `sample_valid` change at the clock edge one quarter SCL period after the STOP's SDA rise. The bench waits for the strobe and samples on the falling clock edge, then checks on the next falling edge that the strobe has dropped. The waits are measured in time between the bus STOP and START events seen by a sensor model in the bench. Each wait is checked against a window from its parameter up to parameter+CLK_DIV+8. The error flag is checked once the restart frame has begun, and again after the sample that clears it.

// File: rtl/als_pkg.sv
package als_pkg;

    localparam int RAW_W = 16;

    localparam logic [6:0] ADDR_PIN_HIGH = 7'b1011100;
    localparam logic [6:0] ADDR_PIN_LOW  = 7'b0100011;
    localparam logic [7:0] CMD_CONT_HRES = 8'h10;
    localparam logic [7:0] CMD_ONCE_HRES = 8'h20;

    typedef enum logic [1:0] {
        E_IDLE,
        E_START,
        E_BIT,
        E_STOP
    } eng_state_e;

    typedef enum logic [2:0] {
        S_PWRUP,
        S_CMD,
        S_CONV,
        S_READ,
        S_GAP
    } seq_state_e;

    typedef struct packed {
        eng_state_e       st;
        logic [1:0]       qtr;
        logic [1:0]       byte_idx;
        logic [3:0]       bit_idx;
        logic             rd;
        logic             scl_low;
        logic             sda_low;
        logic             ack_bad;
        logic             done;
        logic             nack;
        logic [RAW_W-1:0] rx;
    } frm_regs_t;

endpackage

// File: rtl/als_qtick.sv
module als_qtick #(
    parameter int QCYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic qtick
);
    localparam int CW = $clog2(QCYC) + 1;
    localparam logic [CW-1:0] LAST = CW'(QCYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || cnt_q == LAST) cnt_d = '0;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign qtick = run && (cnt_q == LAST);

endmodule

// File: rtl/als_i2c_frame.sv
module als_i2c_frame
    import als_pkg::*;
#(
    parameter int QCYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             go_read,
    input  logic [6:0]       addr7,
    input  logic [7:0]       cmd,
    input  logic             sda_in,
    output logic             scl_low,
    output logic             sda_low,
    output logic             done,
    output logic             nack,
    output logic [RAW_W-1:0] rx_word,
    output eng_state_e       state
);
    frm_regs_t r_d, r_q;
    logic      qtick;
    logic [7:0] tx_byte;
    logic      master_tx;
    logic [1:0] last_byte;

    als_qtick #(.QCYC(QCYC)) u_qtick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (r_q.st != E_IDLE),
        .qtick(qtick)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        tx_byte   = (r_q.byte_idx == 2'd0) ? {addr7, r_q.rd} : cmd;
        master_tx = (r_q.byte_idx == 2'd0) || !r_q.rd;
        last_byte = r_q.rd ? 2'd2 : 2'd1;

        case (r_q.st)
            E_IDLE: begin
                r_d.scl_low = 1'b0;
                r_d.sda_low = 1'b0;
                if (go) begin
                    r_d.st       = E_START;
                    r_d.qtr      = 2'd0;
                    r_d.byte_idx = 2'd0;
                    r_d.bit_idx  = 4'd0;
                    r_d.rd       = go_read;
                    r_d.nack     = 1'b0;
                    r_d.ack_bad  = 1'b0;
                end
            end
            E_START: if (qtick) begin
                r_d.qtr = r_q.qtr + 2'd1;
                if (r_q.qtr == 2'd1) r_d.sda_low = 1'b1;
                if (r_q.qtr == 2'd3) begin
                    r_d.st      = E_BIT;
                    r_d.scl_low = 1'b1;
                end
            end
            E_BIT: if (qtick) begin
                r_d.qtr = r_q.qtr + 2'd1;
                case (r_q.qtr)
                    2'd0: begin
                        if (r_q.bit_idx < 4'd8)
                            r_d.sda_low = master_tx ? !tx_byte[3'd7 - r_q.bit_idx[2:0]] : 1'b0;
                        else
                            r_d.sda_low = master_tx ? 1'b0 : (r_q.byte_idx == 2'd1);
                    end
                    2'd1: r_d.scl_low = 1'b0;
                    2'd2: begin
                        if (r_q.bit_idx < 4'd8 && !master_tx)
                            r_d.rx = {r_q.rx[RAW_W-2:0], sda_in};
                        if (r_q.bit_idx == 4'd8 && master_tx)
                            r_d.ack_bad = sda_in;
                    end
                    default: begin
                        r_d.scl_low = 1'b1;
                        if (r_q.bit_idx == 4'd8) begin
                            r_d.bit_idx  = 4'd0;
                            r_d.byte_idx = r_q.byte_idx + 2'd1;
                            if ((master_tx && r_q.ack_bad) || r_q.byte_idx == last_byte) begin
                                r_d.st   = E_STOP;
                                r_d.nack = master_tx && r_q.ack_bad;
                            end
                        end else begin
                            r_d.bit_idx = r_q.bit_idx + 4'd1;
                        end
                    end
                endcase
            end
            default: if (qtick) begin
                r_d.qtr = r_q.qtr + 2'd1;
                case (r_q.qtr)
                    2'd0: r_d.sda_low = 1'b1;
                    2'd1: r_d.scl_low = 1'b0;
                    2'd2: r_d.sda_low = 1'b0;
                    default: begin
                        r_d.st   = E_IDLE;
                        r_d.done = 1'b1;
                    end
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= E_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_low = r_q.scl_low;
    assign sda_low = r_q.sda_low;
    assign done    = r_q.done;
    assign nack    = r_q.nack;
    assign rx_word = r_q.rx;
    assign state   = r_q.st;

endmodule

// File: rtl/als_lux_scale.sv
module als_lux_scale
    import als_pkg::*;
(
    input  logic [RAW_W-1:0] raw,
    output logic [RAW_W-1:0] lux
);
    localparam int PW = RAW_W + 4;

    logic [PW-1:0] prod;
    logic [PW-1:0] quot;

    always_comb begin
        prod = {4'b0000, raw} * PW'(10);
        quot = prod / PW'(12);
        lux  = quot[RAW_W-1:0];
    end

endmodule

// File: rtl/als_i2c_seq.sv
module als_i2c_seq
    import als_pkg::*;
#(
    parameter int CLK_DIV   = 480,
    parameter int PWRUP_CYC = 48_000_000,
    parameter int CONV_CYC  = 8_640_000,
    parameter int GAP_CYC   = 5_760_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_sel,
    input  logic             oneshot_mode,
    input  logic             sda_in,
    output logic             scl_low,
    output logic             sda_low,
    output logic [RAW_W-1:0] raw_count,
    output logic [RAW_W-1:0] lux,
    output logic             sample_valid,
    output logic             nack_error
);
    localparam int QCYC = CLK_DIV / 4;
    localparam int MAX1 = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC;
    localparam int MAXW = (MAX1 > GAP_CYC) ? MAX1 : GAP_CYC;
    localparam int CW   = $clog2(MAXW + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CW-1:0]    cnt;
        logic             go;
        logic             go_read;
        logic [RAW_W-1:0] raw;
        logic [RAW_W-1:0] lux;
        logic             valid;
        logic             nerr;
    } seq_regs_t;

    seq_regs_t        s_d, s_q;
    logic             frm_done, frm_nack;
    logic [RAW_W-1:0] frm_rx, frm_lux;
    eng_state_e       eng_state;
    logic [6:0]       addr7;
    logic [7:0]       cmd_byte;

    assign addr7    = addr_sel ? ADDR_PIN_HIGH : ADDR_PIN_LOW;
    assign cmd_byte = oneshot_mode ? CMD_ONCE_HRES : CMD_CONT_HRES;

    als_i2c_frame #(.QCYC(QCYC)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (s_q.go),
        .go_read(s_q.go_read),
        .addr7  (addr7),
        .cmd    (cmd_byte),
        .sda_in (sda_in),
        .scl_low(scl_low),
        .sda_low(sda_low),
        .done   (frm_done),
        .nack   (frm_nack),
        .rx_word(frm_rx),
        .state  (eng_state)
    );

    als_lux_scale u_scale (
        .raw(frm_rx),
        .lux(frm_lux)
    );

    always_comb begin
        s_d       = s_q;
        s_d.go    = 1'b0;
        s_d.valid = 1'b0;
        case (s_q.st)
            S_PWRUP: begin
                if (s_q.cnt == '0) begin
                    s_d.st      = S_CMD;
                    s_d.go      = 1'b1;
                    s_d.go_read = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            S_CMD: if (frm_done) begin
                if (frm_nack) begin
                    s_d.nerr    = 1'b1;
                    s_d.go      = 1'b1;
                    s_d.go_read = 1'b0;
                end else begin
                    s_d.st  = S_CONV;
                    s_d.cnt = CW'(CONV_CYC - 1);
                end
            end
            S_READ: if (frm_done) begin
                if (frm_nack) begin
                    s_d.nerr    = 1'b1;
                    s_d.st      = S_CMD;
                    s_d.go      = 1'b1;
                    s_d.go_read = 1'b0;
                end else begin
                    s_d.raw   = frm_rx;
                    s_d.lux   = frm_lux;
                    s_d.valid = 1'b1;
                    s_d.nerr  = 1'b0;
                    if (oneshot_mode) begin
                        s_d.st      = S_CMD;
                        s_d.go      = 1'b1;
                        s_d.go_read = 1'b0;
                    end else begin
                        s_d.st  = S_GAP;
                        s_d.cnt = CW'(GAP_CYC - 1);
                    end
                end
            end
            default: begin
                if (s_q.cnt == '0) begin
                    s_d.st      = S_READ;
                    s_d.go      = 1'b1;
                    s_d.go_read = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.st  <= S_PWRUP;
            s_q.cnt <= CW'(PWRUP_CYC - 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign raw_count    = s_q.raw;
    assign lux          = s_q.lux;
    assign sample_valid = s_q.valid;
    assign nack_error   = s_q.nerr;

endmodule

// File: rtl/als_i2c_seq_chk.sv
module als_i2c_seq_chk
    import als_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_low,
    input logic             sda_low,
    input logic [RAW_W-1:0] raw_count,
    input logic [RAW_W-1:0] lux,
    input logic             sample_valid,
    input logic             nack_error,
    input eng_state_e       eng_state
);
    // R5: data line moves under a released clock only for START/STOP
    p_sda_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_low && $past(!scl_low) && (sda_low != $past(sda_low)))
        |-> (eng_state == E_START || eng_state == E_STOP));

    // R5: lines released between frames
    p_idle_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == E_IDLE) |-> (!scl_low && !sda_low));

    // R7: strobe lasts one cycle
    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R7: scaled value never exceeds the raw count
    p_lux_le_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (lux <= raw_count));

    // R8: error flag only drops together with a good sample
    p_nack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nack_error) |-> sample_valid);

endmodule

bind als_i2c_seq als_i2c_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_low     (scl_low),
    .sda_low     (sda_low),
    .raw_count   (raw_count),
    .lux         (lux),
    .sample_valid(sample_valid),
    .nack_error  (nack_error),
    .eng_state   (eng_state)
);

// File: tb/als_i2c_seq_tb.sv
`timescale 1ns/1ps
module als_i2c_seq_tb;
    localparam int CLK_DIV = 8;
    localparam int PWRUP   = 50;
    localparam int CONV    = 200;
    localparam int GAP     = 120;
    localparam int SLACK   = CLK_DIV + 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic addr_sel = 1'b0;
    logic oneshot = 1'b0;
    logic nack_req = 1'b0;
    logic [15:0] slv_data = 16'h0000;
    time rst_rel = 0;

    logic scl_low, sda_low, valid, nerr;
    logic [15:0] raw, lux;
    logic slv_low;

    wire scl_bus = !scl_low;
    wire sda_bus = !(sda_low || slv_low);

    als_i2c_seq #(
        .CLK_DIV(CLK_DIV), .PWRUP_CYC(PWRUP), .CONV_CYC(CONV), .GAP_CYC(GAP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .oneshot_mode(oneshot),
        .sda_in(sda_bus), .scl_low(scl_low), .sda_low(sda_low),
        .raw_count(raw), .lux(lux), .sample_valid(valid), .nack_error(nerr)
    );

    // sensor model and bus monitor
    int nfr, cur, bitn, bytn;
    logic [7:0] sh;
    logic rd, active, nack_used, prev_scl, prev_sda;
    logic [7:0] fr_addr [16];
    logic [7:0] fr_cmd  [16];
    logic       fr_kind [16];
    logic       fr_ack1 [16];
    logic       fr_ack2 [16];
    time        fr_start[16];
    time        fr_stop [16];
    time        last_rise, scl_per;

    initial begin
        slv_low = 1'b0; prev_scl = 1'b1; prev_sda = 1'b1;
    end

    always @(scl_bus or sda_bus or rst_n) begin
        if (!rst_n) begin
            nfr = 0; cur = 0; bitn = 0; bytn = 0; sh = 8'h00; rd = 1'b0;
            active = 1'b0; nack_used = 1'b0; slv_low = 1'b0;
            last_rise = 0; scl_per = 0;
            for (int i = 0; i < 16; i++) begin
                fr_addr[i] = 8'h00; fr_cmd[i] = 8'h00; fr_kind[i] = 1'b0;
                fr_ack1[i] = 1'bx; fr_ack2[i] = 1'bx; fr_start[i] = 0; fr_stop[i] = 0;
            end
        end else if (prev_scl && scl_bus && prev_sda && !sda_bus) begin
            active = 1'b1; bitn = -1; bytn = 0; rd = 1'b0;
            cur = (nfr < 15) ? nfr : 15;
            fr_start[cur] = $time;
            nfr++;
        end else if (prev_scl && scl_bus && !prev_sda && sda_bus && active) begin
            active = 1'b0; slv_low = 1'b0;
            fr_stop[cur] = $time;
        end else if (!prev_scl && scl_bus && active) begin
            if (last_rise != 0) scl_per = $time - last_rise;
            last_rise = $time;
            if (bitn >= 0 && bitn < 8 && !(rd && bytn >= 1)) sh = {sh[6:0], sda_bus};
            else if (bitn == 8 && rd && bytn == 1) fr_ack1[cur] = sda_bus;
            else if (bitn == 8 && rd && bytn == 2) fr_ack2[cur] = sda_bus;
        end else if (prev_scl && !scl_bus && active) begin
            bitn++;
            if (bitn == 9) begin bitn = 0; bytn++; end
            slv_low = 1'b0;
            if (bitn == 8) begin
                if (bytn == 0) begin
                    rd = sh[0]; fr_addr[cur] = sh; fr_kind[cur] = sh[0];
                    if (nack_req && !nack_used) nack_used = 1'b1;
                    else slv_low = 1'b1;
                end else if (!rd && bytn == 1) begin
                    fr_cmd[cur] = sh; slv_low = 1'b1;
                end
            end else if (rd && bytn >= 1 && bytn <= 2) begin
                slv_low = !slv_data[((bytn == 1) ? 15 : 7) - bitn];
            end
        end
        prev_scl = scl_bus;
        prev_sda = sda_bus;
    end

    int n_checks = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic do_reset(input logic a, input logic m, input logic nk);
        @(negedge clk);
        rst_n = 1'b0; addr_sel = a; oneshot = m; nack_req = nk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rst_rel = $time;
    endtask

    task automatic wait_valid(output bit got);
        got = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (valid) begin got = 1'b1; break; end
        end
    endtask

    function automatic int cycles(input time t);
        return int'(t / 4);
    endfunction

    function automatic bit in_win(input int v, input int lo);
        return (v >= lo) && (v <= lo + SLACK);
    endfunction

    task automatic test_reset();
        do_reset(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check(!scl_low, "R5 scl released after reset", int'(scl_low), 0);
        check(!sda_low, "R5 sda released after reset", int'(sda_low), 0);
        check(!valid, "R7 no strobe after reset", int'(valid), 0);
        check(raw == 16'h0, "R7 raw cleared", int'(raw), 0);
        check(!nerr, "R8 error clear after reset", int'(nerr), 0);
        repeat (PWRUP - 10) @(negedge clk);
        check(nfr == 0, "R4 no frame during power-up wait", nfr, 0);
    endtask

    task automatic test_continuous();
        bit got;
        do_reset(1'b0, 1'b0, 1'b0);
        slv_data = 16'hA5C3;
        wait_valid(got);
        check(got, "R6 first sample arrives", int'(got), 1);
        check(raw == 16'hA5C3, "R6 raw high/low order", int'(raw), 'hA5C3);
        check(int'(lux) == (int'(16'hA5C3) * 10) / 12, "R7 lux scaling", int'(lux), (int'(16'hA5C3) * 10) / 12);
        check(fr_addr[0] == 8'h46, "R1 write address low pin", int'(fr_addr[0]), 'h46);
        check(fr_cmd[0] == 8'h10, "R2 continuous command", int'(fr_cmd[0]), 'h10);
        check(fr_addr[1] == 8'h47, "R1 read address low pin", int'(fr_addr[1]), 'h47);
        check(fr_ack1[1] === 1'b0, "R6 master ACK after high byte", int'(fr_ack1[1]), 0);
        check(fr_ack2[1] === 1'b1, "R6 master NACK after low byte", int'(fr_ack2[1]), 1);
        check(fr_stop[1] > fr_start[1], "R6 read frame ends in STOP", cycles(fr_stop[1]), cycles(fr_start[1]));
        check(cycles(fr_start[0] - rst_rel) >= PWRUP, "R4 power-up wait", cycles(fr_start[0] - rst_rel), PWRUP);
        check(in_win(cycles(fr_start[1] - fr_stop[0]), CONV), "R4 conversion wait", cycles(fr_start[1] - fr_stop[0]), CONV);
        check(scl_per == time'(CLK_DIV * 4), "R9 scl period", int'(scl_per), CLK_DIV * 4);
        @(negedge clk);
        check(!valid, "R7 strobe is one cycle", int'(valid), 0);
        slv_data = 16'hFFFF;
        wait_valid(got);
        check(raw == 16'hFFFF, "R6 second raw", int'(raw), 'hFFFF);
        check(int'(lux) == (65535 * 10) / 12, "R7 lux at full scale", int'(lux), (65535 * 10) / 12);
        check(nfr == 3 && fr_kind[2] == 1'b1, "R2 only reads after command", nfr, 3);
        check(in_win(cycles(fr_start[2] - fr_stop[1]), GAP), "R4 repeat-read gap", cycles(fr_start[2] - fr_stop[1]), GAP);
    endtask

    task automatic test_oneshot();
        bit got;
        do_reset(1'b1, 1'b1, 1'b0);
        slv_data = 16'h1234;
        wait_valid(got);
        check(int'(lux) == (int'(16'h1234) * 10) / 12, "R7 lux one-shot", int'(lux), (int'(16'h1234) * 10) / 12);
        slv_data = 16'h0001;
        wait_valid(got);
        check(raw == 16'h0001 && lux == 16'h0, "R7 small count rounds down", int'(lux), 0);
        check(fr_addr[0] == 8'hB8, "R1 write address high pin", int'(fr_addr[0]), 'hB8);
        check(fr_addr[1] == 8'hB9, "R1 read address high pin", int'(fr_addr[1]), 'hB9);
        check(fr_cmd[0] == 8'h20, "R3 one-shot command", int'(fr_cmd[0]), 'h20);
        check(fr_kind[2] == 1'b0 && fr_cmd[2] == 8'h20, "R3 command repeated before read", int'(fr_cmd[2]), 'h20);
        check(fr_kind[3] == 1'b1, "R3 read follows repeated command", int'(fr_kind[3]), 1);
        check(in_win(cycles(fr_start[3] - fr_stop[2]), CONV), "R4 one-shot conversion wait", cycles(fr_start[3] - fr_stop[2]), CONV);
    endtask

    task automatic test_nack();
        bit got;
        do_reset(1'b0, 1'b0, 1'b1);
        slv_data = 16'h0C00;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (nfr >= 2) break;
        end
        check(nerr, "R8 error flag set", int'(nerr), 1);
        check(fr_stop[0] > fr_start[0], "R8 aborted frame ends in STOP", cycles(fr_stop[0]), cycles(fr_start[0]));
        check(fr_cmd[0] == 8'h00, "R8 no command after missing ACK", int'(fr_cmd[0]), 0);
        wait_valid(got);
        check(fr_kind[1] == 1'b0 && fr_cmd[1] == 8'h10, "R8 restart resends command", int'(fr_cmd[1]), 'h10);
        check(!nerr, "R8 flag cleared by good sample", int'(nerr), 0);
        check(raw == 16'h0C00, "R8 sample after recovery", int'(raw), 'h0C00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_continuous();
        test_oneshot();
        test_nack();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule